// File: doc/BRIEF.md
# Serial Scan Port to Bus Master Bridge

This block lets a debug host reach memory through a boundary-scan test port. It attaches to an existing test access port controller. From that controller it takes the current instruction code and the single-cycle capture, shift and update strobes of the data-register path. Toward the memory system it acts as a single-beat Wishbone master.

Three instruction codes select the bridge. With the address code selected, a 16-bit address register is scanned in, least-significant bit first, and latched on update. With the read code selected, an update starts one read cycle at the latched address. The word returned by that cycle is loaded into the data scan chain at the next capture and scanned out. With the write-read code selected, the word scanned in is written to the latched address on update, and the same scan carries out the most recent read word.

Each update under a transfer code starts exactly one bus cycle. Any update that arrives while a cycle is still open is dropped.

Top module: `jtag_bus_bridge`

## Requirements
- R1: After reset, wb_cyc, wb_stb and wb_we are low, the latched address is 0 and the held read word is 0.
- R2: With ir_code = 8, capture_dr loads the latched address into the address chain. Each shift_dr cycle presents chain bit 0 on tdo and moves tdi in at bit 15, so data travels least-significant bit first. update_dr latches the chain as the new address.
- R3: An update_dr under ir_code = 9 or 10, while no cycle is open, starts one bus cycle at the latched address. wb_cyc and wb_stb rise together in the following clock with every wb_sel bit set. Both stay high until wb_ack, and both are low in the clock after the acknowledge.
- R4: Under ir_code = 9 the cycle has wb_we = 0, and wb_dat_r is stored on wb_ack. The next capture_dr under code 9 or 10 loads that word into the data chain, which shifts it out least-significant bit first.
- R5: Under ir_code = 10 the cycle has wb_we = 1 and wb_dat_w equal to the 16 bits shifted in. The bits shifted out during that scan are the most recently read word.
- R6: An update_dr under code 9 or 10 while wb_cyc is high is ignored. No further cycle starts, and wb_adr, wb_dat_w and wb_we hold their values until the acknowledge.
- R7: Under any other instruction code, tdo is 0 and the strobes change neither the latched address nor the bus port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the test port controller |
| rst | input | 1 | Synchronous active-high reset |
| ir_code | input | IR_W | Instruction currently selected in the controller |
| capture_dr | input | 1 | One-cycle capture strobe of the data-register path |
| shift_dr | input | 1 | Shift enable, one bit per clock |
| update_dr | input | 1 | One-cycle update strobe of the data-register path |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out of the selected chain |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | AW | Bus address |
| wb_dat_w | output | DW | Write data |
| wb_sel | output | DW/8 | Byte selects |
| wb_ack | input | 1 | Acknowledge from the slave |
| wb_dat_r | input | DW | Read data from the slave |

## Verification
The bench builds the bridge with its default values: a 4-bit instruction code, 16-bit address and data, and codes 8, 9 and 10. Two byte selects follow from that data width, and an address and data word each take exactly sixteen shift clocks. It sets the acknowledge latency of its slave per vector, from zero wait states up to a latency longer than a whole scan. The long latency brings an update that lands during an open cycle within reach, so the dropped-update rule can be observed.

// File: rtl/jbb_pkg.sv
package jbb_pkg;
  typedef enum logic [1:0] {
    CHAIN_NONE,
    CHAIN_ADDR,
    CHAIN_READ,
    CHAIN_WRRD
  } chain_sel_e;
endpackage

// File: rtl/jbb_dr_chain.sv
module jbb_dr_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic         shift,
  input  logic [W-1:0] load_val,
  input  logic         tdi,
  output logic [W-1:0] par_out,
  output logic         ser_out
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)          sr_q <= '0;
    else if (capture) sr_q <= load_val;
    else if (shift)   sr_q <= {tdi, sr_q[W-1:1]};
  end

  assign par_out = sr_q;
  assign ser_out = sr_q[0];
endmodule

// File: rtl/jbb_wb_master.sv
module jbb_wb_master #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_rd,
  input  logic          start_wr,
  input  logic [AW-1:0] req_adr,
  input  logic [DW-1:0] req_dat,
  output logic          busy,
  output logic [DW-1:0] rd_word,
  output logic          cyc_o,
  output logic          stb_o,
  output logic          we_o,
  output logic [AW-1:0] adr_o,
  output logic [DW-1:0] dat_o,
  output logic [SW-1:0] sel_o,
  input  logic          ack_i,
  input  logic [DW-1:0] dat_i
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_o   <= 1'b0;
      stb_o   <= 1'b0;
      we_o    <= 1'b0;
      adr_o   <= '0;
      dat_o   <= '0;
      sel_o   <= '0;
      rd_word <= '0;
    end else if (cyc_o) begin
      if (ack_i) begin
        cyc_o <= 1'b0;
        stb_o <= 1'b0;
        we_o  <= 1'b0;
        sel_o <= '0;
        if (!we_o) rd_word <= dat_i;
      end
    end else if (start_rd || start_wr) begin
      cyc_o <= 1'b1;
      stb_o <= 1'b1;
      we_o  <= start_wr;
      adr_o <= req_adr;
      sel_o <= '1;
      if (start_wr) dat_o <= req_dat;
    end
  end

  assign busy = cyc_o;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    cyc_o && !ack_i |=> cyc_o && stb_o);  // R3
  AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    cyc_o && ack_i |=> !cyc_o && !stb_o);  // R3
  AST_FULL_SEL: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_o) |-> stb_o && (sel_o == {SW{1'b1}}));  // R3
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    cyc_o && !ack_i |=> $stable(adr_o) && $stable(dat_o) && $stable(we_o));  // R6
endmodule

// File: rtl/jtag_bus_bridge.sv
module jtag_bus_bridge #(
  parameter int             IR_W      = 4,
  parameter int             AW        = 16,
  parameter int             DW        = 16,
  parameter logic [IR_W-1:0] CODE_ADDR = 4'd8,
  parameter logic [IR_W-1:0] CODE_READ = 4'd9,
  parameter logic [IR_W-1:0] CODE_WRRD = 4'd10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IR_W-1:0] ir_code,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  output logic            tdo,
  output logic            wb_cyc,
  output logic            wb_stb,
  output logic            wb_we,
  output logic [AW-1:0]   wb_adr,
  output logic [DW-1:0]   wb_dat_w,
  output logic [DW/8-1:0] wb_sel,
  input  logic            wb_ack,
  input  logic [DW-1:0]   wb_dat_r
);
  import jbb_pkg::*;

  localparam int SW = DW / 8;

  chain_sel_e    chain;
  logic          data_sel;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_chain;
  logic [DW-1:0] data_chain;
  logic          addr_bit;
  logic          data_bit;
  logic          busy;
  logic [DW-1:0] rd_word;
  logic          start_rd;
  logic          start_wr;

  always_comb begin
    if      (ir_code == CODE_ADDR) chain = CHAIN_ADDR;
    else if (ir_code == CODE_READ) chain = CHAIN_READ;
    else if (ir_code == CODE_WRRD) chain = CHAIN_WRRD;
    else                           chain = CHAIN_NONE;
  end

  assign data_sel = (chain == CHAIN_READ) || (chain == CHAIN_WRRD);

  jbb_dr_chain #(.W(AW)) u_addr_chain (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture_dr && (chain == CHAIN_ADDR)),
    .shift    (shift_dr && (chain == CHAIN_ADDR)),
    .load_val (addr_q),
    .tdi      (tdi),
    .par_out  (addr_chain),
    .ser_out  (addr_bit)
  );

  jbb_dr_chain #(.W(DW)) u_data_chain (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture_dr && data_sel),
    .shift    (shift_dr && data_sel),
    .load_val (rd_word),
    .tdi      (tdi),
    .par_out  (data_chain),
    .ser_out  (data_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)                                   addr_q <= '0;
    else if (update_dr && chain == CHAIN_ADDR) addr_q <= addr_chain;
  end

  assign start_rd = update_dr && (chain == CHAIN_READ) && !busy;
  assign start_wr = update_dr && (chain == CHAIN_WRRD) && !busy;

  always_comb begin
    case (chain)
      CHAIN_ADDR:             tdo = addr_bit;
      CHAIN_READ, CHAIN_WRRD: tdo = data_bit;
      default:                tdo = 1'b0;
    endcase
  end

  jbb_wb_master #(.AW(AW), .DW(DW), .SW(SW)) u_master (
    .clk      (clk),
    .rst      (rst),
    .start_rd (start_rd),
    .start_wr (start_wr),
    .req_adr  (addr_q),
    .req_dat  (data_chain),
    .busy     (busy),
    .rd_word  (rd_word),
    .cyc_o    (wb_cyc),
    .stb_o    (wb_stb),
    .we_o     (wb_we),
    .adr_o    (wb_adr),
    .dat_o    (wb_dat_w),
    .sel_o    (wb_sel),
    .ack_i    (wb_ack),
    .dat_i    (wb_dat_r)
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !(update_dr && chain == CHAIN_ADDR) |=> $stable(addr_q));  // R7
  AST_START_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_cyc) |-> $past(update_dr) && $past(data_sel));  // R3
  AST_IDLE_TDO: assert property (@(posedge clk) disable iff (rst)
    chain == CHAIN_NONE |-> !tdo);  // R7
endmodule

// File: tb/jtag_bus_bridge_test.sv
module jtag_bus_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NVEC = 6;
  // each vector: {address, write word, slave latency}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h0001, 16'hA5C3, 16'd0},
    {16'h0002, 16'h1234, 16'd1},
    {16'h0007, 16'hFFFF, 16'd3},
    {16'h000C, 16'h0001, 16'd0},
    {16'h800E, 16'h8000, 16'd2},
    {16'h0005, 16'h5A5A, 16'd5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] ir_code = 4'd0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic wb_cyc, wb_stb, wb_we, wb_ack;
  logic [AW-1:0] wb_adr;
  logic [DW-1:0] wb_dat_w, wb_dat_r;
  logic [DW/8-1:0] wb_sel;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_bus_bridge uut (
    .clk(clk), .rst(rst), .ir_code(ir_code), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_w(wb_dat_w), .wb_sel(wb_sel), .wb_ack(wb_ack), .wb_dat_r(wb_dat_r)
  );

  // slave model
  logic [15:0] mem [16];
  int lat = 0;
  int wcnt = 0;
  int starts = 0;
  logic prev_cyc = 1'b0;
  logic rec_we;
  logic [AW-1:0] rec_adr;
  logic [DW-1:0] rec_dat;
  logic [DW/8-1:0] rec_sel;

  always @(posedge clk) begin
    if (rst) begin
      wb_ack <= 1'b0;
      wb_dat_r <= '0;
      wcnt <= 0;
      prev_cyc <= 1'b0;
    end else begin
      prev_cyc <= wb_cyc;
      if (wb_cyc && !prev_cyc) starts <= starts + 1;
      wb_ack <= 1'b0;
      if (wb_cyc && wb_stb && !wb_ack) begin
        if (wcnt >= lat) begin
          wcnt <= 0;
          wb_ack <= 1'b1;
          rec_we <= wb_we;
          rec_adr <= wb_adr;
          rec_dat <= wb_dat_w;
          rec_sel <= wb_sel;
          if (wb_we) mem[wb_adr[3:0]] <= wb_dat_w;
          else wb_dat_r <= mem[wb_adr[3:0]];
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [3:0] code, input logic [15:0] din,
                      output logic [15:0] dout);
    @(negedge clk);
    ir_code = code;
    capture_dr = 1'b1;
    @(negedge clk);
    capture_dr = 1'b0;
    for (int i = 0; i < 16; i++) begin
      shift_dr = 1'b1;
      tdi = din[i];
      dout[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 1'b0;
    update_dr = 1'b1;
    @(negedge clk);
    update_dr = 1'b0;
  endtask

  task automatic wait_idle();
    while (wb_cyc) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] so;
    logic [15:0] cur_addr;
    logic [15:0] last_rd;
    int s0;
    for (int i = 0; i < 16; i++) mem[i] = 16'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cyc", {31'd0, wb_cyc}, 0);
    chk("R1 stb", {31'd0, wb_stb}, 0);
    chk("R1 we", {31'd0, wb_we}, 0);
    cur_addr = 16'h0;
    last_rd = 16'h0;

    // table-driven loop
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] a, d;
      a = VEC[v][47:32];
      d = VEC[v][31:16];
      lat = int'(VEC[v][15:0]);
      scan(4'd8, a, so);
      chk(v == 0 ? "R1 addr reset" : "R2 addr readback", {16'd0, so}, {16'd0, cur_addr});
      cur_addr = a;
      scan(4'd10, d, so);
      chk(v == 0 ? "R1 read word reset" : "R5 scan-out read word", {16'd0, so}, {16'd0, last_rd});
      wait_idle();
      chk("R5 write we", {31'd0, rec_we}, 1);
      chk("R5 write adr", {16'd0, rec_adr}, {16'd0, a});
      chk("R5 write data", {16'd0, rec_dat}, {16'd0, d});
      chk("R3 sel", {30'd0, rec_sel}, 32'h3);
      scan(4'd9, 16'h0, so);
      chk("R4 previous word", {16'd0, so}, {16'd0, last_rd});
      wait_idle();
      chk("R4 read we", {31'd0, rec_we}, 0);
      chk("R4 read adr", {16'd0, rec_adr}, {16'd0, a});
      last_rd = d;
      scan(4'd9, 16'h0, so);
      chk("R4 read word out", {16'd0, so}, {16'd0, d});
      wait_idle();
    end

    // R3 cycle timing: cyc/stb rise after update, drop the clock after ack
    lat = 2;
    @(negedge clk);
    ir_code = 4'd9;
    update_dr = 1'b1;
    @(negedge clk);
    update_dr = 1'b0;
    chk("R3 cyc after update", {31'd0, wb_cyc}, 1);
    chk("R3 stb after update", {31'd0, wb_stb}, 1);
    while (!wb_ack) @(negedge clk);
    chk("R3 held during ack", {31'd0, wb_cyc}, 1);
    @(negedge clk);
    chk("R3 cyc released", {31'd0, wb_cyc}, 0);
    chk("R3 stb released", {31'd0, wb_stb}, 0);

    // R6 update during open cycle is dropped
    lat = 40;
    scan(4'd8, 16'h0003, so);
    cur_addr = 16'h0003;
    s0 = starts;
    scan(4'd10, 16'h1111, so);
    scan(4'd10, 16'h2222, so);
    chk("R6 still open", {31'd0, wb_cyc}, 1);
    chk("R6 data held", {16'd0, wb_dat_w}, 32'h1111);
    chk("R6 adr held", {16'd0, wb_adr}, 32'h0003);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R6 one cycle", starts - s0, 1);
    chk("R6 mem", {16'd0, mem[3]}, 32'h1111);
    lat = 0;

    // R7 other codes have no effect
    s0 = starts;
    scan(4'd4, 16'hFFFF, so);
    chk("R7 tdo zero", {16'd0, so}, 0);
    repeat (3) @(negedge clk);
    chk("R7 no cycle", starts - s0, 0);
    scan(4'd8, 16'h0003, so);
    chk("R7 addr unchanged", {16'd0, so}, {16'd0, cur_addr});

    // R1 reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    scan(4'd8, 16'h0, so);
    chk("R1 addr after reset", {16'd0, so}, 0);
    scan(4'd10, 16'h0, so);
    chk("R1 read word after reset", {16'd0, so}, 0);
    wait_idle();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule